// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an 8K x 8 asynchronous static RAM. It turns one single-word read or write request into the strobe sequence that the memory needs. The host holds a request with its address, direction and write data until it sees a one-cycle acknowledge. On a read, the controller selects the memory and enables its outputs. It then waits the worst-case access time, registers the data bus, and releases every strobe. On a write, it drives the data, pulses write enable low for long enough to meet write pulse width, address-to-end-of-write and data setup together, and then releases every strobe on the same edge.

The memory is selected through a pair of chip selects of opposite polarity: an active-low select and an active-high select. Both must be active for the memory to respond. The data bus is modelled as separate in and out vectors plus a drive-enable. The controller keeps its drivers off while the memory's output enable is active, and also for a turnaround window after that enable is released. The memory's output buffers may take up to 30 ns to float. Every time limit, in nanoseconds, is chosen by a speed-grade parameter. Each limit is converted into whole clock cycles by ceiling division, with a floor of one cycle.

Between operations, both selects are inactive, both strobes are high and the drivers are off. After each operation a recovery wait runs. It makes the full cycle time, and after a read also the bus turnaround, pass before the next request can be accepted.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and between operations, memCs1N=1, memCs2=0, memOeN=1, memWeN=1, memDqDrv=0 and ack=0.
- R2: A read (req=1, we=0) holds memCs1N=0, memCs2=1, memOeN=0, memWeN=1 and memAddr=addr for exactly ceil(max(access, OE-to-valid)/CLK_NS) cycles (7 at 10 ns, fast grade). rdata is then the value on memDqIn at the last edge of that window.
- R3: A write (req=1, we=1) holds the select pair active, memOeN=1, memWeN=0, memDqDrv=1 and memDqOut=wdata for exactly ceil(max(write pulse, address-to-end, data setup)/CLK_NS) cycles (6 at 10 ns, fast grade). All these signals are released on one edge.
- R4: Each accepted request gives one ack pulse of exactly one cycle. It rises on the edge that ends the strobe window.
- R5: memDqDrv is never 1 while memOeN=0. It is also never 1 in the first ceil(30/CLK_NS) cycles after memOeN returns to 1.
- R6: A request is accepted only when the controller is idle. After a read, the next operation's strobes start 4 cycles after the ack cycle (3 recovery cycles plus the accept cycle). After a write, they start 2 cycles after it. Successive operation starts are never closer than the minimum cycle time (7 cycles).
- R7: Changes to addr, we or wdata while an operation runs do not affect memAddr or the strobes of that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 13 | Word address |
| wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Registered read data |
| memAddr | output | 13 | Memory address lines |
| memCs1N | output | 1 | Active-low chip select |
| memCs2 | output | 1 | Active-high chip select |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memDqOut | output | 8 | Data driven toward the memory |
| memDqDrv | output | 1 | Drive enable for memDqOut |
| memDqIn | input | 8 | Data seen on the memory bus |

## Verification
The bench goes after the exact strobe widths. A window one cycle short would break access or write-pulse timing, and a window one cycle long would waste bandwidth. Both show up as a wrong count of low cycles. It issues a write right after a read with the request held high throughout. A design that skipped the turnaround would enable its drivers while the memory still drives the bus, and a design that accepted requests during recovery would start the next operation too early. It also changes the host inputs in the middle of an operation to catch a controller that passes live inputs to the memory. Finally, it reads back values written at the extreme addresses, so that a data or address path that is swapped, late or unregistered returns the wrong byte.

// File: rtl/asram_pkg.sv
package asram_pkg;

  // strobes the sequencer hands to the datapath; each field is the value
  // the corresponding memory pin takes during the next clock cycle
  typedef struct packed {
    logic load;     // capture host address and write data
    logic sel;      // select pair active
    logic oe;       // output enable active
    logic wr;       // write enable active
    logic drv;      // data drivers on
    logic capture;  // register the read data
  } strobe_t;

  function automatic int cyc(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC = 7,
  parameter int RD_REC = 3,
  parameter int WR_CYC = 6,
  parameter int WR_REC = 1,
  parameter int CW     = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    req,
  input  logic    we,
  output strobe_t stb,
  output logic    ack
);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_REC} state_t;

  state_t        state, nState;
  logic [CW-1:0] cnt, nCnt;
  logic          lastCyc;

  assign lastCyc = (cnt == CW'(1));

  always_comb begin
    stb    = '0;
    nState = state;
    nCnt   = cnt;
    unique case (state)
      ST_IDLE: if (req) begin
        nState   = we ? ST_WRITE : ST_READ;
        nCnt     = we ? CW'(WR_CYC) : CW'(RD_CYC);
        stb.load = 1'b1;
        stb.sel  = 1'b1;
        stb.oe   = ~we;
        stb.wr   = we;
        stb.drv  = we;
      end
      ST_READ: begin
        if (lastCyc) begin
          stb.capture = 1'b1;
          nState      = ST_REC;
          nCnt        = CW'(RD_REC);
        end else begin
          stb.sel = 1'b1;
          stb.oe  = 1'b1;
          nCnt    = cnt - CW'(1);
        end
      end
      ST_WRITE: begin
        if (lastCyc) begin
          nState = ST_REC;
          nCnt   = CW'(WR_REC);
        end else begin
          stb.sel = 1'b1;
          stb.wr  = 1'b1;
          stb.drv = 1'b1;
          nCnt    = cnt - CW'(1);
        end
      end
      ST_REC: begin
        if (lastCyc) nState = ST_IDLE;
        else         nCnt   = cnt - CW'(1);
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      ack   <= 1'b0;
    end else begin
      state <= nState;
      cnt   <= nCnt;
      ack   <= (state == ST_READ || state == ST_WRITE) && lastCyc;
    end
  end

  // R4: acknowledge lasts a single cycle
  a_r4_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  // R6: a request is taken only from idle; busy states never reload strobes
  a_r6_accept_idle: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> (state == ST_IDLE));

  // R4: ack always follows a finished access, never a recovery
  a_r4_ack_after_access: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> (state == ST_REC));

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath
  import asram_pkg::*;
#(
  parameter int AW   = 13,
  parameter int DW   = 8,
  parameter int TURN = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] memDqIn,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] memAddr,
  output logic          memCs1N,
  output logic          memCs2,
  output logic          memOeN,
  output logic          memWeN,
  output logic [DW-1:0] memDqOut,
  output logic          memDqDrv
);

  localparam int TW = (TURN < 2) ? 1 : $clog2(TURN + 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
      rdata    <= '0;
      memCs1N  <= 1'b1;
      memCs2   <= 1'b0;
      memOeN   <= 1'b1;
      memWeN   <= 1'b1;
      memDqDrv <= 1'b0;
    end else begin
      if (stb.load) begin
        memAddr  <= addr;
        memDqOut <= wdata;
      end
      if (stb.capture) rdata <= memDqIn;
      memCs1N  <= ~stb.sel;
      memCs2   <= stb.sel;
      memOeN   <= ~stb.oe;
      memWeN   <= ~stb.wr;
      memDqDrv <= stb.drv;
    end
  end

  // cycles of output enable inactive, saturating at TURN (checker state)
  logic [TW-1:0] sinceOe;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      sinceOe <= TW'(TURN);
    else if (!memOeN)               sinceOe <= '0;
    else if (sinceOe != TW'(TURN))  sinceOe <= sinceOe + TW'(1);
  end

  // R5: controller and memory never drive the bus together
  a_r5_no_drive_with_oe: assert property (@(posedge clk) disable iff (!rstN)
    memDqDrv |-> memOeN);

  // R5: turnaround window after output enable release
  a_r5_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    memDqDrv |-> (sinceOe >= TW'(TURN)));

  // R3: a write strobe is always backed by driven data and disabled outputs
  a_r3_write_drive: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memDqDrv && memOeN));

  // R2: strobes only while the select pair is active
  a_r2_strobe_selected: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || !memWeN) |-> (!memCs1N && memCs2));

  // R7: address frozen for as long as the memory stays selected
  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memCs1N && $past(!memCs1N)) |-> $stable(memAddr));

  // R1: the two selects always move together
  a_r1_select_pair: assert property (@(posedge clk) disable iff (!rstN)
    memCs1N != memCs2);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter bit SLOW   = 1'b0,
  parameter int AW     = 13,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] memAddr,
  output logic          memCs1N,
  output logic          memCs2,
  output logic          memOeN,
  output logic          memWeN,
  output logic [DW-1:0] memDqOut,
  output logic          memDqDrv,
  input  logic [DW-1:0] memDqIn
);

  // limits in ns for the chosen speed grade
  localparam int T_RC   = SLOW ? 100 : 70;
  localparam int T_AA   = SLOW ? 100 : 70;
  localparam int T_OE   = SLOW ? 50  : 35;
  localparam int T_WC   = SLOW ? 100 : 70;
  localparam int T_WP   = SLOW ? 60  : 45;
  localparam int T_AW   = SLOW ? 80  : 60;
  localparam int T_DW   = SLOW ? 40  : 30;
  localparam int T_HZ   = 30;

  localparam int RD_CYC = cyc(imax(T_AA, T_OE), CLK_NS);
  localparam int TURN   = cyc(T_HZ, CLK_NS);
  localparam int RD_REC = imax(cyc(T_RC, CLK_NS) - RD_CYC, TURN);
  localparam int WR_CYC = cyc(imax(T_WP, imax(T_AW, T_DW)), CLK_NS);
  localparam int WR_REC = imax(cyc(T_WC, CLK_NS) - WR_CYC, 1);
  localparam int CW     = $clog2(imax(imax(RD_CYC, RD_REC), imax(WR_CYC, WR_REC)) + 1);

  strobe_t stb;

  asram_seq #(
    .RD_CYC(RD_CYC), .RD_REC(RD_REC), .WR_CYC(WR_CYC), .WR_REC(WR_REC), .CW(CW)
  ) u_seq (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .stb(stb), .ack(ack)
  );

  asram_dpath #(.AW(AW), .DW(DW), .TURN(TURN)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wdata(wdata),
    .memDqIn(memDqIn), .rdata(rdata), .memAddr(memAddr), .memCs1N(memCs1N),
    .memCs2(memCs2), .memOeN(memOeN), .memWeN(memWeN), .memDqOut(memDqOut),
    .memDqDrv(memDqDrv)
  );

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ack;
  logic [7:0]  rdata, memDqOut, memDqIn;
  logic [12:0] memAddr;
  logic        memCs1N, memCs2, memOeN, memWeN, memDqDrv;

  int total = 0, bad = 0, cycNo = 0;

  function automatic int ceilNs(input int ns);
    int c;
    c = (ns + 9) / 10;
    return (c < 1) ? 1 : c;
  endfunction

  // expected counts from the fast-grade limits at 10 ns
  int expRd, expWr, expTurn, expMinCyc;
  initial begin
    expRd     = ceilNs(70);   // max of 70 access, 35 OE
    expWr     = ceilNs(60);   // max of 45 pulse, 60 addr-to-end, 30 setup
    expTurn   = ceilNs(30);
    expMinCyc = ceilNs(70);
  end

  always #5 clk = ~clk;

  asram_ctrl u_dut (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .memAddr(memAddr), .memCs1N(memCs1N),
    .memCs2(memCs2), .memOeN(memOeN), .memWeN(memWeN), .memDqOut(memDqOut),
    .memDqDrv(memDqDrv), .memDqIn(memDqIn)
  );

  // memory model: 256 bytes indexed by the low address byte
  logic [7:0] mem [256];
  logic       sel;
  assign sel     = !memCs1N && memCs2;
  assign memDqIn = (sel && !memOeN && memWeN) ? mem[memAddr[7:0]] : 8'hEE;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitors: write capture, turnaround, start spacing
  int  oeHigh = 100, lastStart = -1000;
  bit  prevSel = 1'b0;
  always @(negedge clk) begin
    cycNo++;
    if (sel && !memWeN) mem[memAddr[7:0]] = memDqOut;
    if (memDqDrv && (oeHigh < expTurn))
      chk(1'b0, "R5 drive inside turnaround", oeHigh, expTurn);
    if (memDqDrv && !memOeN) chk(1'b0, "R5 drive with OE", 1, 0);
    oeHigh = memOeN ? oeHigh + 1 : 0;
    if (sel && !prevSel) begin
      chk(cycNo - lastStart >= expMinCyc, "R6 start spacing", cycNo - lastStart, expMinCyc);
      lastStart = cycNo;
    end
    prevSel = sel;
  end

  initial begin
    #1500000;
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chkIdle(input string tag);
    chk(memCs1N && !memCs2 && memOeN && memWeN && !memDqDrv && !ack, tag,
        {memCs1N, memCs2, memOeN, memWeN, memDqDrv, ack}, 6'b101100);
  endtask

  // read; optionally disturb host inputs mid-operation (R7)
  task automatic doRead(input logic [12:0] a, input logic [7:0] exp, input bit disturb,
                        input bit keepReq);
    int n = 0, guard = 0;
    bit ok = 1'b1;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    while (!ack && guard < 100) begin
      guard++;
      if (!memOeN) begin
        n++;
        if (memAddr != a || !sel || !memWeN) ok = 1'b0;
      end
      if (disturb && n == 2) begin addr = ~a; wdata = 8'h3C; end
      @(negedge clk);
    end
    chk(n == expRd, "R2 read OE width", n, expRd);
    chk(ok, "R2/R7 read address and strobes held", ok, 1);
    chk(rdata == exp, "R2 read data", rdata, exp);
    if (!keepReq) begin
      req = 1'b0;
      @(negedge clk);
      chk(!ack, "R4 ack single cycle", ack, 0);
    end
  endtask

  task automatic doWrite(input logic [12:0] a, input logic [7:0] d, input bit disturb);
    int n = 0, guard = 0;
    bit ok = 1'b1;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    while (!ack && guard < 100) begin
      guard++;
      if (!memWeN) begin
        n++;
        if (memAddr != a || memDqOut != d || !memDqDrv || !memOeN || !sel) ok = 1'b0;
      end
      if (disturb && n == 3) begin addr = a ^ 13'h0F0F; wdata = ~d; we = 1'b0; end
      @(negedge clk);
    end
    chk(n == expWr, "R3 write WE width", n, expWr);
    chk(ok, "R3/R7 write address, data, drive held", ok, 1);
    chk(!memDqDrv && memWeN && !sel, "R3 release together", {memDqDrv, memWeN, sel}, 3'b010);
    req = 1'b0;
    @(negedge clk);
    chk(!ack, "R4 ack single cycle", ack, 0);
  endtask

  // read then write with req held high throughout (R5, R6)
  task automatic readThenWrite();
    int gap = 0;
    doRead(13'h0ABC, 8'hA5, 1'b0, 1'b1);
    we = 1'b1; addr = 13'h0042; wdata = 8'h77;   // req stays high
    @(negedge clk);
    gap = 1;
    while (memWeN && gap < 50) begin @(negedge clk); gap++; end
    chk(gap == 4, "R6 read-to-write start gap", gap, 4);
    while (!ack && gap < 100) begin @(negedge clk); gap++; end
    req = 1'b0;
    @(negedge clk);
    chk(mem[8'h42] == 8'h77, "R3 write after read stored", mem[8'h42], 8'h77);
  endtask

  task automatic writeThenRead();
    int gap = 0;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 13'h0100; wdata = 8'hC3;
    while (!ack) @(negedge clk);
    we = 1'b0;   // req held, next op is a read
    @(negedge clk);
    gap = 1;
    while (memOeN && gap < 50) begin @(negedge clk); gap++; end
    chk(gap == 2, "R6 write-to-read start gap", gap, 2);
    while (!ack) @(negedge clk);
    chk(rdata == 8'hC3, "R2 read after write", rdata, 8'hC3);
    req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chkIdle("R1 reset state");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chkIdle("R1 idle after reset");

    doWrite(13'h0000, 8'h5A, 1'b0);
    doWrite(13'h1FFF, 8'hFF, 1'b0);
    doWrite(13'h0ABC, 8'hA5, 1'b1);
    doWrite(13'h1234, 8'h00, 1'b0);
    chkIdle("R1 idle between operations");
    chk(mem[8'hBC] == 8'hA5, "R7 write unaffected by host change", mem[8'hBC], 8'hA5);
    chk(mem[8'hB3] == 8'h00, "R7 no stray write", mem[8'hB3], 8'h00);

    doRead(13'h0000, 8'h5A, 1'b0, 1'b0);
    doRead(13'h1FFF, 8'hFF, 1'b0, 1'b0);
    doRead(13'h1234, 8'h00, 1'b1, 1'b0);

    readThenWrite();
    writeThenRead();
    repeat (6) @(negedge clk);
    chkIdle("R1 idle at end");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule